// File: doc/BRIEF.md
# Time-Shared MAC Thermal Predictor

This block evaluates a small two-layer feed-forward neural network that turns per-element utilization figures into predicted temperature increments. A fixed pool of multiply-accumulate lanes is shared by every neuron of both layers. A controller steps through each neuron's connections one lane group per cycle and keeps a separate partial sum for each lane. When a neuron's last group is done, it adds the partial sums, scales and saturates the total, and then either passes it through an activation table (hidden layer) or uses it directly as a temperature increment (output layer).

Activations of the hidden layer are written into the upper part of the same register array that holds the 8-bit utilization inputs. The output layer then reads its operands from there through the unchanged datapath. Each output increment updates a per-element temperature accumulator. The accumulator is seeded from an initial temperature on a first run and carried over on later runs. At the end of a run every accumulator is compared with its own threshold entry, which gives one status bit per element.

A host loads the utilization inputs through a write port. Weights, activation table and thresholds are loaded through a shared configuration port. The host then pulses start and waits for the done pulse.

Top module: `thermal_mac_predictor`

## Requirements
- R1: A start pulse while idle begins a run. busy stays high until done. done is a one-cycle pulse that rises exactly N_HID*(ceil(N_IN/N_MAC)+1) + N_OUT*(ceil(N_HID/N_MAC)+1) + 1 clock edges after the edge that sampled start (37 with default parameters). A start pulse while busy has no effect.
- R2: Hidden neuron h forms the sum over i of input[i]*weight[h*N_IN+i]. Inputs are unsigned 8-bit and weights are signed 8-bit.
- R3: A hidden sum is arithmetically shifted right by SHIFT (6) and saturated to the range -128..127. The result plus 128 indexes the 256-entry activation table.
- R4: Hidden activations are stored in register entries N_IN+h and are the operands of the output layer. Output neuron o uses the weights at N_HID*N_IN + o*N_HID + h.
- R5: Output neurons are linear. Their sum, arithmetically shifted right by SHIFT, is added to the temperature of that element.
- R6: When first is high with start, every temperature is loaded from init_temp before the increments are added. When first is low, the increments are added to the temperatures left by the previous run.
- R7: A temperature update that falls below 0 gives 0. One that exceeds 2^TW-1 (65535) gives 2^TW-1.
- R8: At done, status[o] is 1 when temperature o is greater than or equal to threshold o, and 0 otherwise. status and temps hold their values until the next done.
- R9: Input writes and configuration writes presented while busy are ignored.
- R10: On the configuration port, cfg_sel 0 writes weight cfg_addr (low 8 bits of cfg_data, two's complement), 1 writes activation entry cfg_addr (low 8 bits), and 2 writes threshold cfg_addr (all TW bits).
- R11: After reset, busy, done, status and all temperatures are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a prediction run |
| first | input | 1 | With start: seed temperatures from init_temp |
| init_temp | input | TW | Initial temperature for a first run |
| in_we | input | 1 | Utilization input write enable |
| in_addr | input | clog2(N_IN) | Input register index |
| in_data | input | DW | Utilization value |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Target: 0 weights, 1 activation table, 2 thresholds |
| cfg_addr | input | CFG_AW | Entry index within the target |
| cfg_data | input | TW | Write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | N_OUT | Per-element over-threshold bits |
| temps | output | N_OUT*TW | Accumulated temperatures, element o at bits o*TW |

## Verification
The hardest situations to reach from the ports are the saturation corners. A hidden sum must be driven past the 8-bit activation index in both directions, and a temperature must be pushed across both ends of its range. Directed runs do this: all inputs are set to full scale and all hidden weights to the extreme positive or negative value. Distinctive activation entries are placed at the two end indices, and the output weights are then set to extremes with an initial temperature near the top or bottom of the range. The threshold equal-to boundary is hit by first predicting a run's temperatures and then reloading thresholds equal to and one above them before the same run is repeated.

// File: rtl/thermal_mac_predictor.sv
`timescale 1ns/1ps
module thermal_mac_predictor #(
  parameter int N_IN   = 10,
  parameter int N_HID  = 6,
  parameter int N_OUT  = 4,
  parameter int N_MAC  = 4,
  parameter int DW     = 8,
  parameter int WW     = 8,
  parameter int AW     = 24,
  parameter int TW     = 16,
  parameter int SHIFT  = 6,
  parameter int CFG_AW = 8
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  first,
  input  logic [TW-1:0]         init_temp,
  input  logic                  in_we,
  input  logic [$clog2(N_IN)-1:0] in_addr,
  input  logic [DW-1:0]         in_data,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [TW-1:0]         cfg_data,
  output logic                  busy,
  output logic                  done,
  output logic [N_OUT-1:0]      status,
  output logic [N_OUT*TW-1:0]   temps
);
  localparam int G1   = (N_IN + N_MAC - 1) / N_MAC;
  localparam int G2   = (N_HID + N_MAC - 1) / N_MAC;
  localparam int GMX  = (G1 > G2) ? G1 : G2;
  localparam int GW   = $clog2(GMX + 1);
  localparam int NMX  = (N_HID > N_OUT) ? N_HID : N_OUT;
  localparam int NW   = $clog2(NMX + 1);
  localparam int NREG = N_IN + N_HID;
  localparam int RW   = $clog2(NREG);
  localparam int WD   = N_HID * N_IN + N_OUT * N_HID;
  localparam int WAW  = $clog2(WD);
  localparam int OW   = $clog2(N_OUT);
  localparam int LUTN = 1 << DW;
  localparam logic signed [AW-1:0] SMAX = AW'((1 << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);
  localparam logic signed [AW:0]   TMAX = (AW+1)'((64'd1 << TW) - 1);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_FIN, S_CMP} st_t;

  st_t                     st;
  logic                    layer;
  logic [NW-1:0]           neu;
  logic [GW-1:0]           grp;
  logic                    done_q;
  logic [N_OUT-1:0]        stat_q;

  logic [DW-1:0]           xr   [NREG];
  logic signed [WW-1:0]    wmem [WD];
  logic [DW-1:0]           alut [LUTN];
  logic [TW-1:0]           thr  [N_OUT];
  logic [TW-1:0]           tacc [N_OUT];
  logic signed [AW-1:0]    macc [N_MAC];
  logic signed [AW-1:0]    prod [N_MAC];

  assign busy   = (st != S_IDLE);
  assign done   = done_q;
  assign status = stat_q;

  for (genvar o = 0; o < N_OUT; o++) begin : g_tout
    assign temps[o*TW +: TW] = tacc[o];
  end

  for (genvar k = 0; k < N_MAC; k++) begin : g_lane
    int                   idx;
    logic                 ok;
    logic [RW-1:0]        xa;
    logic [WAW-1:0]       wa;
    logic [DW-1:0]        xv;
    logic signed [WW-1:0] wv;
    assign idx = int'(grp) * N_MAC + k;
    assign ok  = idx < (layer ? N_HID : N_IN);
    assign xa  = RW'(ok ? (layer ? N_IN + idx : idx) : 0);
    assign wa  = WAW'(ok ? (layer ? N_HID*N_IN + int'(neu)*N_HID + idx
                                  : int'(neu)*N_IN + idx) : 0);
    assign xv  = xr[xa];
    assign wv  = wmem[wa];
    assign prod[k] = ok ? AW'($signed({1'b0, xv})) * AW'(wv) : '0;
  end

  logic signed [AW-1:0] tot, sh;
  always_comb begin
    tot = '0;
    for (int k = 0; k < N_MAC; k++) tot = tot + macc[k];
  end
  assign sh = tot >>> SHIFT;

  logic signed [DW-1:0] hs;
  logic [DW-1:0]        aidx, act;
  assign hs   = (sh > SMAX) ? DW'(SMAX) : (sh < SMIN) ? DW'(SMIN) : DW'(sh);
  assign aidx = {~hs[DW-1], hs[DW-2:0]};
  assign act  = alut[aidx];

  logic [TW-1:0]      tcur, tnew;
  logic signed [AW:0] tsum;
  assign tcur = tacc[OW'(neu)];
  assign tsum = (AW+1)'($signed({1'b0, tcur})) + (AW+1)'(sh);
  assign tnew = (tsum < 0) ? '0 : (tsum > TMAX) ? '1 : TW'(tsum);

  logic [GW-1:0] glast;
  logic [NW-1:0] nlast;
  assign glast = layer ? GW'(G2 - 1) : GW'(G1 - 1);
  assign nlast = layer ? NW'(N_OUT - 1) : NW'(N_HID - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      layer  <= 1'b0;
      neu    <= '0;
      grp    <= '0;
      done_q <= 1'b0;
      stat_q <= '0;
      for (int o = 0; o < N_OUT; o++) tacc[o] <= '0;
      for (int k = 0; k < N_MAC; k++) macc[k] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_ACC;
          layer <= 1'b0;
          neu   <= '0;
          grp   <= '0;
          if (first) for (int o = 0; o < N_OUT; o++) tacc[o] <= init_temp;
        end
        S_ACC: begin
          for (int k = 0; k < N_MAC; k++) macc[k] <= macc[k] + prod[k];
          if (grp == glast) st <= S_FIN;
          else grp <= grp + 1'b1;
        end
        S_FIN: begin
          for (int k = 0; k < N_MAC; k++) macc[k] <= '0;
          grp <= '0;
          if (layer) tacc[OW'(neu)] <= tnew;
          if (neu == nlast) begin
            neu <= '0;
            if (!layer) begin
              layer <= 1'b1;
              st    <= S_ACC;
            end else begin
              st <= S_CMP;
            end
          end else begin
            neu <= neu + 1'b1;
            st  <= S_ACC;
          end
        end
        S_CMP: begin
          for (int o = 0; o < N_OUT; o++) stat_q[o] <= (tacc[o] >= thr[o]);
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && in_we && int'(in_addr) < N_IN) xr[RW'(in_addr)] <= in_data;
    if (st == S_FIN && !layer) xr[RW'(N_IN + int'(neu))] <= act;
    if (!busy && cfg_we) begin
      case (cfg_sel)
        2'd0: if (int'(cfg_addr) < WD)    wmem[WAW'(cfg_addr)] <= cfg_data[WW-1:0];
        2'd1: if (int'(cfg_addr) < LUTN)  alut[DW'(cfg_addr)]  <= cfg_data[DW-1:0];
        2'd2: if (int'(cfg_addr) < N_OUT) thr[OW'(cfg_addr)]   <= cfg_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/thermal_mac_predictor_chk.sv
`timescale 1ns/1ps
module thermal_mac_predictor_chk #(
  parameter int N_OUT = 4,
  parameter int TW    = 16
)(
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                first,
  input logic [TW-1:0]       init_temp,
  input logic                busy,
  input logic                done,
  input logic [N_OUT-1:0]    status,
  input logic [N_OUT*TW-1:0] temps
);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status));
  p_temps_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(temps));
  p_first_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && first) |=> (temps == {N_OUT{$past(init_temp)}}));
endmodule

bind thermal_mac_predictor thermal_mac_predictor_chk #(.N_OUT(N_OUT), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .first(first), .init_temp(init_temp),
  .busy(busy), .done(done), .status(status), .temps(temps)
);

// File: tb/thermal_mac_predictor_tb.sv
`timescale 1ns/1ps
module thermal_mac_predictor_tb;
  localparam int N_IN = 10, N_HID = 6, N_OUT = 4, N_MAC = 4;
  localparam int DW = 8, TW = 16, SHIFT = 6, CFG_AW = 8;
  localparam int WD = N_HID*N_IN + N_OUT*N_HID;
  localparam int LAT = N_HID*((N_IN+N_MAC-1)/N_MAC + 1) + N_OUT*((N_HID+N_MAC-1)/N_MAC + 1) + 1;
  localparam int TMX = (1 << TW) - 1;

  logic clk = 0, rst_n = 0, start = 0, first = 0;
  logic [TW-1:0] init_temp = '0;
  logic in_we = 0;
  logic [$clog2(N_IN)-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [TW-1:0] cfg_data = '0;
  logic busy, done;
  logic [N_OUT-1:0] status;
  logic [N_OUT*TW-1:0] temps;

  thermal_mac_predictor #(.N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT), .N_MAC(N_MAC),
    .DW(DW), .TW(TW), .SHIFT(SHIFT), .CFG_AW(CFG_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first(first), .init_temp(init_temp),
    .in_we(in_we), .in_addr(in_addr), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .busy(busy), .done(done), .status(status), .temps(temps));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0;
  int mx[N_IN], mw[WD], ma[256], mthr[N_OUT], mt[N_OUT];
  bit ms[N_OUT];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_in(input int a, input int d);
    in_we = 1; in_addr = a[$clog2(N_IN)-1:0]; in_data = d[DW-1:0];
    @(posedge clk); @(negedge clk); in_we = 0;
  endtask

  task automatic wr_cfg(input int sel, input int a, input int d);
    cfg_we = 1; cfg_sel = sel[1:0]; cfg_addr = a[CFG_AW-1:0]; cfg_data = d[TW-1:0];
    @(posedge clk); @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_in(input int i, input int v);  mx[i] = v; wr_in(i, v); endtask
  task automatic set_w(input int a, input int v);   mw[a] = v; wr_cfg(0, a, v & 255); endtask
  task automatic set_act(input int a, input int v); ma[a] = v; wr_cfg(1, a, v); endtask
  task automatic set_thr(input int o, input int v); mthr[o] = v; wr_cfg(2, o, v); endtask

  task automatic model_run(input bit fst, input int init);
    int hid[N_HID];
    int s, v;
    if (fst) for (int o = 0; o < N_OUT; o++) mt[o] = init;
    for (int h = 0; h < N_HID; h++) begin
      s = 0;
      for (int i = 0; i < N_IN; i++) s += mx[i] * mw[h*N_IN + i];
      v = s >>> SHIFT;
      if (v > 127) v = 127;
      if (v < -128) v = -128;
      hid[h] = ma[v + 128];
    end
    for (int o = 0; o < N_OUT; o++) begin
      s = 0;
      for (int h = 0; h < N_HID; h++) s += hid[h] * mw[N_HID*N_IN + o*N_HID + h];
      v = mt[o] + (s >>> SHIFT);
      if (v < 0) v = 0;
      if (v > TMX) v = TMX;
      mt[o] = v;
      ms[o] = (mt[o] >= mthr[o]);
    end
  endtask

  task automatic wait_done(input int c0, input string req);
    while (!done && (cyc - c0) < 500) @(negedge clk);
    chk(cyc - c0 == LAT, req, cyc - c0, LAT);
  endtask

  task automatic run_chk(input bit fst, input int init, input string req);
    int c0;
    start = 1; first = fst; init_temp = init[TW-1:0];
    @(posedge clk); @(negedge clk);
    start = 0; c0 = cyc;
    wait_done(c0, "R1 latency");
    model_run(fst, init);
    for (int o = 0; o < N_OUT; o++)
      chk(int'(temps[o*TW +: TW]) == mt[o], req, int'(temps[o*TW +: TW]), mt[o]);
    for (int o = 0; o < N_OUT; o++)
      chk(status[o] == ms[o], "R8 status", int'(status[o]), int'(ms[o]));
    @(negedge clk);
    chk(!done, "R1 done pulse", int'(done), 0);
  endtask

  task automatic rand_cfg();
    for (int a = 0; a < WD; a++) set_w(a, int'($urandom_range(0, 255)) - 128);
  endtask

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R11 reset busy/done", int'({busy, done}), 0);
    chk(status == '0, "R11 reset status", int'(status), 0);
    chk(temps == '0, "R11 reset temps", int'(temps[31:0]), 0);
    rst_n = 1;
    @(negedge clk);
    chk(temps == '0 && status == '0, "R11 after reset", int'(status), 0);

    for (int a = 0; a < 256; a++) set_act(a, int'($urandom_range(0, 255)));
    rand_cfg();
    for (int o = 0; o < N_OUT; o++) set_thr(o, int'($urandom_range(0, 65535)));
    for (int i = 0; i < N_IN; i++) set_in(i, int'($urandom_range(0, 255)));
    run_chk(1'b1, 30000, "R2 R4 R5 R10 first run");

    for (int it = 0; it < 16; it++) begin
      if (it % 4 == 3) rand_cfg();
      for (int i = 0; i < N_IN; i++) set_in(i, int'($urandom_range(0, 255)));
      for (int o = 0; o < N_OUT; o++) set_thr(o, mt[o] + int'($urandom_range(0, 4000)) - 2000);
      run_chk(it % 3 == 0, int'($urandom_range(5000, 50000)), "R5 R6 random run");
    end

    // R3: hidden sums saturated at both ends of the activation index
    set_act(255, 200); set_act(0, 17); set_act(128, 99);
    for (int i = 0; i < N_IN; i++) set_in(i, 255);
    for (int a = 0; a < N_HID*N_IN; a++) set_w(a, 127);
    for (int a = N_HID*N_IN; a < WD; a++) set_w(a, int'($urandom_range(0, 40)) - 20);
    run_chk(1'b1, 20000, "R3 positive saturation");
    for (int a = 0; a < N_HID*N_IN; a++) set_w(a, -128);
    run_chk(1'b1, 20000, "R3 negative saturation");

    // R7: clamp at both ends of the temperature range
    for (int a = 0; a < N_HID*N_IN; a++) set_w(a, 127);
    for (int a = N_HID*N_IN; a < WD; a++) set_w(a, 127);
    run_chk(1'b1, 65000, "R7 clamp high");
    for (int o = 0; o < N_OUT; o++)
      chk(int'(temps[o*TW +: TW]) == TMX, "R7 clamp high value", int'(temps[o*TW +: TW]), TMX);
    for (int a = N_HID*N_IN; a < WD; a++) set_w(a, -128);
    run_chk(1'b1, 1000, "R7 clamp low");
    for (int o = 0; o < N_OUT; o++)
      chk(temps[o*TW +: TW] == '0, "R7 clamp low value", int'(temps[o*TW +: TW]), 0);

    // R8: equal-to threshold boundary
    rand_cfg();
    for (int i = 0; i < N_IN; i++) set_in(i, int'($urandom_range(0, 255)));
    run_chk(1'b1, 30000, "R8 boundary setup");
    for (int o = 0; o < N_OUT; o++) set_thr(o, mt[o] + (o % 2));
    run_chk(1'b1, 30000, "R8 boundary rerun");
    for (int o = 0; o < N_OUT; o++)
      chk(status[o] == ((o % 2) == 0), "R8 equal threshold", int'(status[o]), int'((o % 2) == 0));

    // R8: hold while idle, even across input writes
    begin
      logic [N_OUT-1:0] s0;
      logic [N_OUT*TW-1:0] t0;
      s0 = status; t0 = temps;
      repeat (10) @(negedge clk);
      for (int i = 0; i < N_IN; i++) set_in(i, int'($urandom_range(0, 255)));
      chk(status == s0, "R8 status hold", int'(status), int'(s0));
      chk(temps == t0, "R8 temps hold", int'(temps[TW-1:0]), int'(t0[TW-1:0]));
    end

    // R9 and R1: writes and a second start during a run are ignored
    begin
      int c0;
      start = 1; first = 1; init_temp = 16'd25000;
      @(posedge clk); @(negedge clk);
      start = 0; c0 = cyc;
      wr_in(0, int'(mx[0]) ^ 255);
      wr_in(N_IN - 1, int'(mx[N_IN-1]) ^ 170);
      wr_cfg(0, 0, (mw[0] + 77) & 255);
      wr_cfg(0, N_HID*N_IN, (mw[N_HID*N_IN] + 55) & 255);
      wr_cfg(1, 128, 3);
      start = 1; first = 1; init_temp = 16'd100;
      @(posedge clk); @(negedge clk);
      start = 0;
      wait_done(c0, "R1 start while busy latency");
      model_run(1'b1, 25000);
      for (int o = 0; o < N_OUT; o++)
        chk(int'(temps[o*TW +: TW]) == mt[o], "R9 R1 busy writes ignored",
            int'(temps[o*TW +: TW]), mt[o]);
      @(negedge clk);
      chk(!busy, "R1 second start ignored", int'(busy), 0);
      run_chk(1'b0, 0, "R9 R6 rerun after busy writes");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule